// File: doc/BRIEF.md
# CAN Fault-Confinement Interrupt Flags

This block follows the fault-confinement state of a CAN node and raises latched interrupt flags when that state changes. It takes the transmit error counter (9 bits) and the receive error counter (8 bits) as inputs. The counters are maintained elsewhere. The block also takes a one-cycle strobe for each received run of eleven consecutive recessive bits. From these it derives a state code: error-active, error-passive or bus-off.

Three flags sit behind a write-one-to-clear register port:

- a bus-off flag, which fires both when the node enters bus-off and when it returns from bus-off to error-active;
- an error-passive flag;
- a receive-warning flag, which looks only at the receive counter.

Each flag is set on the rising edge of its condition. Software can therefore clear a flag while the condition still holds, and the flag will not set again until the condition goes away and comes back. The OR of all flags drives a single interrupt request.

None of the interfaces carries a data stream. The counters, the strobe and the register write are plain control and status pins. There is no back-pressure and no valid/ready handshake. A write is taken in every cycle in which its enable is high.

Top module: `can_fault_flags`

## Requirements
- R1: While the state is not bus-off, a transmit count of 256 or more moves the state to bus-off (state code 2'b10) at the next clock edge.
- R2: In bus-off, the state returns to error-active (2'b00) on the 128th recessive-run strobe counted since bus-off was entered. Strobes received outside bus-off do not count.
- R3: The bus-off flag (flag bit 2) sets on the edge where the state enters bus-off. It sets again on the edge where the state leaves bus-off for error-active.
- R4: The error-passive flag (flag bit 1) sets one edge after the condition "transmit count ≥ 128 or receive count ≥ 128" goes from false to true.
- R5: The receive-warning flag (flag bit 0) sets one edge after the condition "receive count ≥ 96" goes from false to true. The transmit count has no effect on this flag.
- R6: A register write with data bit k equal to 0 leaves flag bit k unchanged.
- R7: A register write with data bit k equal to 1 clears flag bit k, even while its condition still holds. The flag stays clear until the condition falls and rises again.
- R8: If a set event and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R9: Outside bus-off, the state code is 2'b01 (error-passive) when the passive condition holds and 2'b00 otherwise. Bus-off (2'b10) takes priority over error-passive.
- R10: The interrupt request is high exactly when at least one flag is set.
- R11: A synchronous reset clears all flags and the recovery count, and sets the state to error-active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tec_i | input | 9 | Transmit error count |
| rec_i | input | 8 | Receive error count |
| rcv11_i | input | 1 | One-cycle strobe per received run of 11 recessive bits |
| wr_en_i | input | 1 | Flag register write enable |
| wr_data_i | input | 3 | Write data; a 1 clears the matching flag (bit 2 bus-off, bit 1 passive, bit 0 warning) |
| flags_o | output | 3 | Latched flags (bit 2 bus-off, bit 1 passive, bit 0 warning) |
| irq_o | output | 1 | OR of all flags |
| state_o | output | 2 | 00 error-active, 01 error-passive, 10 bus-off |

## Verification
The bench uses several kinds of counter pattern.

- **Receive count alone.** The receive count is raised to 95, 96, 127 and 128. This locates the warning and passive thresholds exactly.
- **Transmit count alone.** The transmit count is held just under the passive threshold. This shows that it cannot raise the warning flag.
- **Bus-off recovery.** A bus-off episode is driven with recessive-run strobes sent both before and during bus-off. This tells apart a recovery counter that starts fresh on entry and counts only in bus-off from one that also counts outside bus-off. Stopping at 127 and 128 strobes pins down the exit cycle.
- **Clears and writes.** Clears are issued while conditions persist, and again in the same cycle as a rising condition. This separates edge-triggered from level-triggered setting, and shows which of set and clear wins. Zero-data writes show that writing 0 has no effect.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_PASSIVE = 2'b01,
    ST_BUSOFF  = 2'b10
  } fc_state_e;

  localparam int unsigned FLAG_WARN = 0;
  localparam int unsigned FLAG_PASS = 1;
  localparam int unsigned FLAG_BOFF = 2;
  localparam int unsigned N_FLAGS   = 3;
endpackage

// File: rtl/can_fc_cond.sv
// Threshold compare on the error counts with rising-edge detection.
module can_fc_cond #(
  parameter int unsigned TEC_W    = 9,
  parameter int unsigned REC_W    = 8,
  parameter int unsigned PASS_LIM = 128,
  parameter int unsigned WARN_LIM = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TEC_W-1:0] tec_i,
  input  logic [REC_W-1:0] rec_i,
  output logic             pass_lvl_o,
  output logic             pass_rise_o,
  output logic             warn_rise_o
);
  localparam logic [TEC_W-1:0] TEC_PASS_TH = TEC_W'(PASS_LIM);
  localparam logic [REC_W-1:0] REC_PASS_TH = REC_W'(PASS_LIM);
  localparam logic [REC_W-1:0] REC_WARN_TH = REC_W'(WARN_LIM);

  logic pass_now, warn_now;
  logic pass_q, warn_q;

  assign pass_now = (tec_i >= TEC_PASS_TH) || (rec_i >= REC_PASS_TH);
  assign warn_now = (rec_i >= REC_WARN_TH);

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      pass_q <= pass_now;
      warn_q <= warn_now;
    end
  end

  assign pass_lvl_o  = pass_now;
  assign pass_rise_o = pass_now & ~pass_q;
  assign warn_rise_o = warn_now & ~warn_q;
endmodule

// File: rtl/can_fc_state.sv
// Error-state register and bus-off recovery counter.
module can_fc_state
  import can_fc_pkg::*;
#(
  parameter int unsigned TEC_W     = 9,
  parameter int unsigned BOFF_LIM  = 256,
  parameter int unsigned RECOV_CNT = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TEC_W-1:0] tec_i,
  input  logic             pass_lvl_i,
  input  logic             rcv11_i,
  output fc_state_e        state_o,
  output logic             boff_evt_o
);
  localparam int unsigned CNT_W = (RECOV_CNT > 1) ? $clog2(RECOV_CNT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECOV_CNT - 1);
  localparam logic [TEC_W-1:0] TEC_BOFF_TH = TEC_W'(BOFF_LIM);

  fc_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (st_q == ST_BUSOFF) begin
      if (rcv11_i) begin
        if (cnt_q == CNT_LAST) begin
          st_d  = ST_ACTIVE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (tec_i >= TEC_BOFF_TH) begin
      st_d  = ST_BUSOFF;
      cnt_d = '0;
    end else if (pass_lvl_i) begin
      st_d = ST_PASSIVE;
    end else begin
      st_d = ST_ACTIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_ACTIVE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // Entry into bus-off, or return from bus-off to error-active.
  assign boff_evt_o = (st_q != ST_BUSOFF && st_d == ST_BUSOFF) ||
                      (st_q == ST_BUSOFF && st_d == ST_ACTIVE);
  assign state_o = st_q;
endmodule

// File: rtl/can_fc_flags.sv
// Bank of write-one-to-clear latches; a set event wins over a clear.
module can_fc_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] flags_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic f_q;
    logic clr;
    assign clr = wr_en_i & wr_data_i[k];
    always_ff @(posedge clk) begin
      if (rst)           f_q <= 1'b0;
      else if (set_i[k]) f_q <= 1'b1;
      else if (clr)      f_q <= 1'b0;
    end
    assign flags_o[k] = f_q;
  end
endmodule

// File: rtl/can_fault_flags.sv
module can_fault_flags
  import can_fc_pkg::*;
#(
  parameter int unsigned TEC_W     = 9,
  parameter int unsigned REC_W     = 8,
  parameter int unsigned PASS_LIM  = 128,
  parameter int unsigned WARN_LIM  = 96,
  parameter int unsigned BOFF_LIM  = 256,
  parameter int unsigned RECOV_CNT = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TEC_W-1:0]   tec_i,
  input  logic [REC_W-1:0]   rec_i,
  input  logic               rcv11_i,
  input  logic               wr_en_i,
  input  logic [N_FLAGS-1:0] wr_data_i,
  output logic [N_FLAGS-1:0] flags_o,
  output logic               irq_o,
  output logic [1:0]         state_o
);
  logic         pass_lvl, pass_rise, warn_rise, boff_evt;
  fc_state_e    st;
  logic [N_FLAGS-1:0] set_vec;

  can_fc_cond #(
    .TEC_W(TEC_W), .REC_W(REC_W), .PASS_LIM(PASS_LIM), .WARN_LIM(WARN_LIM)
  ) u_cond (
    .clk(clk), .rst(rst), .tec_i(tec_i), .rec_i(rec_i),
    .pass_lvl_o(pass_lvl), .pass_rise_o(pass_rise), .warn_rise_o(warn_rise)
  );

  can_fc_state #(
    .TEC_W(TEC_W), .BOFF_LIM(BOFF_LIM), .RECOV_CNT(RECOV_CNT)
  ) u_state (
    .clk(clk), .rst(rst), .tec_i(tec_i), .pass_lvl_i(pass_lvl),
    .rcv11_i(rcv11_i), .state_o(st), .boff_evt_o(boff_evt)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_WARN] = warn_rise;
    set_vec[FLAG_PASS] = pass_rise;
    set_vec[FLAG_BOFF] = boff_evt;
  end

  can_fc_flags #(.N(N_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .flags_o(flags_o)
  );

  assign irq_o   = |flags_o;
  assign state_o = st;
endmodule

// File: rtl/can_fc_chk.sv
module can_fc_chk #(
  parameter int unsigned TEC_W     = 9,
  parameter int unsigned REC_W     = 8,
  parameter int unsigned WARN_LIM  = 96,
  parameter int unsigned BOFF_LIM  = 256,
  parameter int unsigned RECOV_CNT = 128
) (
  input logic             clk,
  input logic             rst,
  input logic [TEC_W-1:0] tec_i,
  input logic [REC_W-1:0] rec_i,
  input logic             rcv11_i,
  input logic             wr_en_i,
  input logic [2:0]       wr_data_i,
  input logic [2:0]       flags_o,
  input logic [1:0]       state_o
);
  logic [31:0] ck_cnt;
  logic [2:0]  keep_q;

  always_ff @(posedge clk) begin
    if (rst || state_o != 2'b10) ck_cnt <= 0;
    else if (rcv11_i)            ck_cnt <= ck_cnt + 1;
  end

  always_ff @(posedge clk) begin
    if (rst) keep_q <= '0;
    else     keep_q <= flags_o & ~(wr_en_i ? wr_data_i : 3'b000);
  end

  a_r1_enter_busoff: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'b10 && tec_i >= TEC_W'(BOFF_LIM)) |=> state_o == 2'b10);

  a_r2_recover_on_last: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b10 && rcv11_i && ck_cnt == RECOV_CNT - 1) |=> state_o == 2'b00);

  a_r2_hold_busoff: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b10 && !(rcv11_i && ck_cnt == RECOV_CNT - 1)) |=> state_o == 2'b10);

  a_r3_flag_on_exit: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && $past(state_o) == 2'b10) |-> flags_o[2]);

  a_r3_flag_on_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(state_o[1]) |-> flags_o[2]);

  a_r6_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (flags_o & keep_q) == keep_q);

  a_r7_warn_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_data_i[0] && rec_i < REC_W'(WARN_LIM)) |=> !flags_o[0]);
endmodule

bind can_fault_flags can_fc_chk #(
  .TEC_W(TEC_W), .REC_W(REC_W), .WARN_LIM(WARN_LIM),
  .BOFF_LIM(BOFF_LIM), .RECOV_CNT(RECOV_CNT)
) u_chk (
  .clk(clk), .rst(rst), .tec_i(tec_i), .rec_i(rec_i), .rcv11_i(rcv11_i),
  .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .flags_o(flags_o), .state_o(state_o)
);

// File: tb/can_fault_flags_tb.sv
module can_fault_flags_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] tec = '0;
  logic [7:0] rec = '0;
  logic       rcv11 = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_data = '0;
  logic [2:0] flags;
  logic       irq;
  logic [1:0] state;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_flags u_dut (
    .clk(clk), .rst(rst), .tec_i(tec), .rec_i(rec), .rcv11_i(rcv11),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .flags_o(flags), .irq_o(irq),
    .state_o(state)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tec = '0; rec = '0; rcv11 = 1'b0; wr_en = 1'b0; wr_data = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic strobe();
    rcv11 = 1'b1; tick(); rcv11 = 1'b0; tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 flags", flags, 3'b000);
    chk("R11 state", state, 2'b00);
    chk("R10 irq idle", irq, 1'b0);
  endtask

  task automatic t_warn();
    do_reset();
    tec = 9'd127; tick(); tick();
    chk("R5 tec no warn", flags, 3'b000);
    rec = 8'd95; tick();
    chk("R5 rec 95", flags, 3'b000);
    rec = 8'd96; tick();
    chk("R5 rec 96", flags, 3'b001);
    chk("R10 irq set", irq, 1'b1);
    chk("R9 active", state, 2'b00);
  endtask

  task automatic t_passive();
    do_reset();
    rec = 8'd127; tick();
    chk("R4 rec 127", flags, 3'b001);
    rec = 8'd128; tick();
    chk("R4 rec 128", flags, 3'b011);
    chk("R9 passive", state, 2'b01);
    wr(3'b010);
    chk("R7 clear held", flags, 3'b001);
    tick(); tick();
    chk("R7 no reset", flags, 3'b001);
    chk("R9 still passive", state, 2'b01);
    rec = 8'd0; tick();
    rec = 8'd130; tick();
    chk("R7 rearm", flags, 3'b011);
    wr(3'b000);
    chk("R6 zero write", flags, 3'b011);
    wr(3'b011);
    chk("R7 clear both", flags, 3'b000);
    chk("R10 irq clear", irq, 1'b0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    rec = 8'd100; wr_en = 1'b1; wr_data = 3'b001; tick();
    wr_en = 1'b0; wr_data = '0;
    chk("R8 set wins", flags, 3'b001);
  endtask

  task automatic t_busoff();
    do_reset();
    for (int i = 0; i < 5; i++) strobe();
    chk("R2 strobes idle", state, 2'b00);
    tec = 9'd255; tick();
    chk("R1 tec 255", state, 2'b01);
    tec = 9'd256; tick();
    chk("R1 enter", state, 2'b10);
    chk("R3 entry flag", flags, 3'b110);
    chk("R9 priority", state, 2'b10);
    wr(3'b111);
    chk("R7 clear in busoff", flags, 3'b000);
    chk("R7 stays busoff", state, 2'b10);
    tec = 9'd0; tick();
    for (int i = 0; i < 127; i++) strobe();
    chk("R2 after 127", state, 2'b10);
    chk("R3 no early flag", flags, 3'b000);
    rcv11 = 1'b1; tick(); rcv11 = 1'b0;
    chk("R2 after 128", state, 2'b00);
    chk("R3 exit flag", flags, 3'b100);
  endtask

  initial begin
    t_reset();
    t_warn();
    t_passive();
    t_same_cycle();
    t_busoff();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule